// File: doc/BRIEF.md
# Overwrite-Oldest Event Log Queue

This block is a circular store of tagged trace events shared by a producer and a consumer on one clock. Every event carries a 3-bit kind and an 8-bit payload, and is kept as a 16-bit word. The producer is never held off. When the store already holds its maximum of 63 events, a new event evicts the oldest one and a sticky loss flag records that history was lost.

Debug-kind events are filtered at the input: they are kept only while the debug enable is high, and every other kind is always kept. The consumer asks for one word per request. The answer appears on the output one cycle later and stays there until the next request. If the store was empty, the answer is the sentinel 0xFFFF. A level output reports how many events are held.

Top module: `evlog_queue`

## Requirements
- R1: During and after reset the level is 0, the pop output reads 0xFFFF and the loss flag is 0.
- R2: Events are popped in arrival order. A popped word is {5'b0, kind[2:0], payload[7:0]}, with the kind in bits 10:8 and the payload in bits 7:0. It appears on the pop output in the cycle after the request and holds until the next request. A lone push raises the level by one and a lone pop lowers it by one.
- R3: With 63 events held, a push without a pop discards the oldest event, keeps the level at 63 and sets the loss flag. Later pops skip the discarded event.
- R4: An event of kind 0 (debug) is stored only while debug_en is 1, and it leaves the level unchanged otherwise. Kinds 1 to 5 (start, stop, address with write, address with read, data byte) are always stored.
- R5: A pop request on an empty queue yields 0xFFFF and leaves the level at 0.
- R6: A push and a pop in the same cycle with 63 events held return the oldest event, keep the level at 63 and do not set the loss flag.
- R7: The loss flag stays set until loss_clr is 1. If an eviction happens in the same cycle as loss_clr, the flag stays set.
- R8: A push and a pop in the same cycle on an empty queue yield 0xFFFF and store the pushed event, so the level becomes 1.
- R9: A push and a pop in the same cycle on a queue holding between 1 and 62 events leave the level unchanged and keep arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by producer and consumer |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Producer offers an event this cycle |
| ev_kind | input | 3 | Event kind code |
| ev_payload | input | 8 | Event payload byte |
| debug_en | input | 1 | Admit kind-0 (debug) events |
| pop_req | input | 1 | Consumer requests the oldest word |
| pop_word | output | 16 | Word returned for the last request, 0xFFFF if it found the queue empty |
| level | output | 6 | Number of events held, 0 to 63 |
| loss | output | 1 | Sticky flag: an event was evicted |
| loss_clr | input | 1 | Clears the loss flag |

## Verification
The bench fills the queue to 63 and keeps pushing, then drains it. A design that evicts one event too late, or that lets the write pointer catch the read pointer, returns a stale or duplicated word or reports a level that wraps to 0. Same-cycle push and pop is tried on an empty, a partly filled and a full queue. Getting it wrong there shows up as a lost event, a false loss flag, or a real event returned in place of the empty sentinel. Debug-kind events are offered with the enable low and then high, and the clear of the loss flag is issued in the same cycle as an eviction, where a design that gives the clear priority would drop the flag.

// File: rtl/evlog_pkg.sv
package evlog_pkg;

    localparam int unsigned KIND_W    = 3;
    localparam int unsigned PAYLOAD_W = 8;
    localparam int unsigned WORD_W    = 16;
    localparam int unsigned PAD_W     = WORD_W - KIND_W - PAYLOAD_W;

    typedef enum logic [KIND_W-1:0] {
        EVK_TRACE   = 3'd0,
        EVK_BEGIN   = 3'd1,
        EVK_END     = 3'd2,
        EVK_ADDR_WR = 3'd3,
        EVK_ADDR_RD = 3'd4,
        EVK_BYTE    = 3'd5
    } ev_kind_e;

    localparam logic [WORD_W-1:0] EMPTY_WORD = '1;

    function automatic logic [WORD_W-1:0] pack_word(
        input logic [KIND_W-1:0]    kind,
        input logic [PAYLOAD_W-1:0] payload
    );
        return {{PAD_W{1'b0}}, kind, payload};
    endfunction

endpackage

// File: rtl/evlog_admit.sv
module evlog_admit
    import evlog_pkg::*;
(
    input  logic              ev_valid,
    input  logic [KIND_W-1:0] ev_kind,
    input  logic              debug_en,
    output logic              accept
);
    logic is_trace;

    always_comb begin
        is_trace = (ev_kind == EVK_TRACE);
        accept   = ev_valid && (!is_trace || debug_en);
    end
endmodule

// File: rtl/evlog_ctrl.sv
module evlog_ctrl #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          pop_req,
    input  logic          loss_clr,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic          pop_hit,
    output logic [AW-1:0] level,
    output logic          loss
);
    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic          loss;
    } ctrl_t;

    ctrl_t state_d, state_q;
    logic  empty_c, full_c, evict_c;

    always_comb begin
        state_d = state_q;
        empty_c = (state_q.wr == state_q.rd);
        full_c  = (AW'(state_q.wr + 1'b1) == state_q.rd);
        pop_hit = pop_req && !empty_c;
        evict_c = accept && full_c && !pop_hit;

        if (accept) begin
            state_d.wr = state_q.wr + 1'b1;
        end
        if (pop_hit || evict_c) begin
            state_d.rd = state_q.rd + 1'b1;
        end
        if (evict_c) begin
            state_d.loss = 1'b1;
        end else if (loss_clr) begin
            state_d.loss = 1'b0;
        end

        wr_en   = accept;
        wr_addr = state_q.wr;
        rd_addr = state_q.rd;
        level   = state_q.wr - state_q.rd;
        loss    = state_q.loss;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/evlog_store.sv
module evlog_store #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned WIDTH = 16,
    parameter int unsigned AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata = mem_q[raddr];
    end
endmodule

// File: rtl/evlog_queue.sv
module evlog_queue
    import evlog_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned AW    = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ev_valid,
    input  logic [KIND_W-1:0]    ev_kind,
    input  logic [PAYLOAD_W-1:0] ev_payload,
    input  logic                 debug_en,
    input  logic                 pop_req,
    output logic [WORD_W-1:0]    pop_word,
    output logic [AW-1:0]        level,
    output logic                 loss,
    input  logic                 loss_clr
);
    logic              accept;
    logic              wr_en;
    logic [AW-1:0]     wr_addr;
    logic [AW-1:0]     rd_addr;
    logic              pop_hit;
    logic [WORD_W-1:0] wr_word;
    logic [WORD_W-1:0] rd_word;
    logic [WORD_W-1:0] out_d, out_q;

    evlog_admit u_admit (
        .ev_valid (ev_valid),
        .ev_kind  (ev_kind),
        .debug_en (debug_en),
        .accept   (accept)
    );

    evlog_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .pop_req  (pop_req),
        .loss_clr (loss_clr),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .rd_addr  (rd_addr),
        .pop_hit  (pop_hit),
        .level    (level),
        .loss     (loss)
    );

    evlog_store #(.DEPTH(DEPTH), .WIDTH(WORD_W), .AW(AW)) u_store (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_word),
        .raddr (rd_addr),
        .rdata (rd_word)
    );

    always_comb begin
        wr_word = pack_word(ev_kind, ev_payload);
        out_d   = out_q;
        if (pop_req) begin
            out_d = pop_hit ? rd_word : EMPTY_WORD;
        end
        pop_word = out_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= EMPTY_WORD;
        end else begin
            out_q <= out_d;
        end
    end
endmodule

// File: rtl/evlog_queue_chk.sv
module evlog_queue_chk #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned AW    = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ev_valid,
    input logic [2:0]    ev_kind,
    input logic          debug_en,
    input logic          pop_req,
    input logic [15:0]   pop_word,
    input logic [AW-1:0] level,
    input logic          loss,
    input logic          loss_clr
);
    localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

    logic taken;
    always_comb begin
        taken = ev_valid && ((ev_kind != 3'd0) || debug_en);
    end

    p_grow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && !pop_req && level != TOP) |=> (level == AW'($past(level) + 1'b1)));

    p_shrink_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!taken && pop_req && level != '0) |=> (level == AW'($past(level) - 1'b1)));

    p_evict_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && !pop_req && level == TOP) |=> (level == TOP && loss));

    p_trace_filter_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_kind == 3'd0 && !debug_en && !pop_req) |=> $stable(level));

    p_empty_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && level == '0) |=> (pop_word == 16'hFFFF));

    p_full_swap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && pop_req && level == TOP && !loss_clr) |=> (level == TOP && $stable(loss)));

    p_loss_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (loss && !loss_clr) |=> loss);

    p_word_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pop_req) |=> $stable(pop_word));
endmodule

bind evlog_queue evlog_queue_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_valid (ev_valid),
    .ev_kind  (ev_kind),
    .debug_en (debug_en),
    .pop_req  (pop_req),
    .pop_word (pop_word),
    .level    (level),
    .loss     (loss),
    .loss_clr (loss_clr)
);

// File: tb/sim_evlog_queue.sv
`timescale 1ns/1ps
module sim_evlog_queue;
    localparam int CAP = 63;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_valid = 1'b0;
    logic [2:0]  ev_kind = '0;
    logic [7:0]  ev_payload = '0;
    logic        debug_en = 1'b0;
    logic        pop_req = 1'b0;
    logic [15:0] pop_word;
    logic [5:0]  level;
    logic        loss;
    logic        loss_clr = 1'b0;

    int tests = 0;
    int fails = 0;

    logic [15:0] model_q[$];
    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic        model_loss = 1'b0;

    always #2 clk = ~clk;

    evlog_queue u0 (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
        .ev_payload(ev_payload), .debug_en(debug_en), .pop_req(pop_req),
        .pop_word(pop_word), .level(level), .loss(loss), .loss_clr(loss_clr)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor: compares each popped word one edge after its request
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            check(tag_q.pop_front(), "pop_word", {16'h0, pop_word}, {16'h0, exp_q.pop_front()});
        end
    end

    // driver: one cycle of stimulus, with the model updated alongside
    task automatic step(input bit v, input logic [2:0] k, input logic [7:0] p,
                        input bit dbg, input bit pop, input bit clr, input string req);
        logic [15:0] got;
        bit evict;
        @(negedge clk);
        ev_valid = v; ev_kind = k; ev_payload = p;
        debug_en = dbg; pop_req = pop; loss_clr = clr;
        evict = 1'b0;
        if (pop) begin
            got = (model_q.size() > 0) ? model_q.pop_front() : 16'hFFFF;
            exp_q.push_back(got);
            tag_q.push_back(req);
        end
        if (v && (k != 3'd0 || dbg)) begin
            model_q.push_back({5'b0, k, p});
            if (model_q.size() > CAP) begin
                void'(model_q.pop_front());
                evict = 1'b1;
            end
        end
        if (evict) model_loss = 1'b1;
        else if (clr) model_loss = 1'b0;
        @(posedge clk);
        #1;
        check(req, "level", {26'h0, level}, model_q.size());
        check(req, "loss", {31'h0, loss}, {31'h0, model_loss});
    endtask

    task automatic idle();
        @(negedge clk);
        ev_valid = 0; pop_req = 0; loss_clr = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", "level in reset", {26'h0, level}, 0);
        check("R1", "pop_word in reset", {16'h0, pop_word}, 32'hFFFF);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1", "level after reset", {26'h0, level}, 0);
        check("R1", "loss after reset", {31'h0, loss}, 0);
        check("R1", "pop_word after reset", {16'h0, pop_word}, 32'hFFFF);

        // R5: pop from empty
        step(0, 0, 0, 0, 1, 0, "R5");

        // R2: order and word layout, each kind
        for (int i = 1; i <= 5; i++) step(1, 3'(i), 8'(8'h30 + i), 0, 0, 0, "R2");
        for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 1, 0, "R2");
        idle();
        repeat (2) @(posedge clk);
        #1;
        check("R2", "pop_word held", {16'h0, pop_word}, 32'h0535);

        // R4: debug filtering
        step(1, 3'd0, 8'hA1, 0, 0, 0, "R4");
        step(1, 3'd2, 8'hA2, 0, 0, 0, "R4");
        step(1, 3'd0, 8'hA3, 1, 0, 0, "R4");
        step(0, 0, 0, 0, 1, 0, "R4");
        step(0, 0, 0, 0, 1, 0, "R4");
        step(0, 0, 0, 0, 1, 0, "R4");

        // R8: push and pop on empty
        step(1, 3'd5, 8'h77, 0, 1, 0, "R8");
        step(0, 0, 0, 0, 1, 0, "R8");

        // R9: push and pop with some held
        for (int i = 0; i < 3; i++) step(1, 3'd5, 8'(8'h10 + i), 0, 0, 0, "R9");
        for (int i = 0; i < 4; i++) step(1, 3'd3, 8'(8'h20 + i), 0, 1, 0, "R9");
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, 0, "R9");

        // R3: fill, then overflow
        for (int i = 0; i < CAP; i++) step(1, 3'(1 + i % 5), 8'(i), 0, 0, 0, "R3");
        for (int i = 0; i < 3; i++) step(1, 3'd5, 8'(8'hC0 + i), 0, 0, 0, "R3");

        // R6: full, push and pop together
        step(1, 3'd4, 8'hD0, 0, 1, 0, "R6");

        // R7: clear, then eviction with clear in the same cycle
        step(0, 0, 0, 0, 0, 1, "R7");
        step(0, 0, 0, 0, 0, 0, "R7");
        step(1, 3'd1, 8'hE0, 0, 0, 1, "R7");
        step(0, 0, 0, 0, 0, 0, "R7");

        // R3: drain, discarded events must be absent
        for (int i = 0; i < CAP; i++) step(0, 0, 0, 0, 1, 0, "R3");
        step(0, 0, 0, 0, 1, 0, "R5");
        idle();
        repeat (3) @(posedge clk);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule